// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Controller

This block is the host side of the handshake that moves a bidirectional parallel port link out of compatibility mode and back again. A single request carries an 8-bit extensibility code. The controller places that code on the data lines and strobes it to the attached device. It then reads the device's status lines and decides whether the requested mode was accepted. A second request runs the termination handshake, which returns the link to compatibility mode with the data path facing forward. Every wait is bounded by a limit counted in pulses of a tick-enable input, so the same logic serves any clock rate.

Each operation ends with a two-bit result: 0 accepted, 1 timeout, 2 I/O error, 3 mode not supported. The result and the done flag stay put until the next request is taken. The four peripheral status inputs and the acknowledge input are asynchronous. Each passes through a two-flop synchronizer before the controller compares it with anything. The data phase that follows a negotiation belongs to other logic and is not part of this block.

Top module: `pp_negotiator`

## Requirements
- R1: After reset the host pins sit at the compatibility idle state: host_selin_n=0, host_afd_n=1, host_stb_n=1, host_init_n=1. Also ctl_busy=0, ctl_done=0, link_active=0 and data_out=0.
- R2: A negotiation request that arrives while host_selin_n is already 1 is refused at once. ctl_done=1 with ctl_result=2 (I/O error) appears on the cycle after the request. ctl_busy stays 0 and the pins and link_active do not change.
- R3: An accepted negotiation loads neg_mode onto data_out and holds it there. The pins stay idle for SETUP_TICKS tick pulses. The controller then drives host_selin_n=1, host_afd_n=0, host_stb_n=1 and host_init_n=1.
- R4: The controller then waits for periph_perror, periph_select and periph_fault_n all high with periph_ack_n low. If RESP_TICKS tick pulses pass first, the result is 1 (timeout), which in total is SETUP_TICKS+RESP_TICKS ticks of busy time.
- R5: Once that response is seen, host_stb_n goes low for SETUP_TICKS tick pulses while host_afd_n stays low. Then host_stb_n and host_afd_n both return high.
- R6: The controller then waits up to SETUP_TICKS+RESP_TICKS tick pulses for periph_ack_n high. If it does not come, the result is 2 (I/O error).
- R7: When periph_ack_n goes high, mode code 0x00 is always accepted. Any other code is accepted only if periph_select is high at that moment, and otherwise gives result 3 (not supported). link_active becomes 1 only with result 0.
- R8: A termination request drives host_selin_n=0 with host_afd_n, host_stb_n and host_init_n high. It then waits up to SETUP_TICKS+RESP_TICKS ticks for periph_busy and periph_fault_n high with periph_ack_n low. A timeout gives result 2 and leaves the pins idle.
- R9: Termination then pulls host_afd_n low and waits up to RESP_TICKS ticks for periph_ack_n high. Whether that succeeds (result 0) or times out (result 2), host_afd_n returns high. Every termination ends with link_active=0 and the pins idle.
- R10: ctl_busy is high from the cycle after an accepted request until the operation ends. ctl_done and ctl_result are then held until the next request is taken. Requests made while ctl_busy is high are ignored, and a negotiation request wins over a termination request raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable; each high cycle is one tick |
| neg_req | input | 1 | Start a negotiation (taken when idle) |
| neg_mode | input | 8 | Extensibility code for the negotiation |
| term_req | input | 1 | Start a termination (taken when idle) |
| periph_ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| periph_busy | input | 1 | Peripheral busy status, asynchronous |
| periph_perror | input | 1 | Peripheral paper-error status, asynchronous |
| periph_select | input | 1 | Peripheral select status, asynchronous |
| periph_fault_n | input | 1 | Peripheral fault status, active low, asynchronous |
| data_out | output | 8 | Data lines toward the peripheral |
| host_selin_n | output | 1 | Host select-in line, active low |
| host_afd_n | output | 1 | Host auto-feed line, active low |
| host_stb_n | output | 1 | Host strobe line, active low |
| host_init_n | output | 1 | Host initialize line, active low |
| ctl_busy | output | 1 | Operation in progress |
| ctl_done | output | 1 | Last operation finished; held |
| ctl_result | output | 2 | 0 ok, 1 timeout, 2 I/O error, 3 not supported |
| link_active | output | 1 | Link is in a negotiated mode |

## Verification
The hardest cases to reach are the refusal of a request and a timeout in the second half of termination. A refusal needs host_selin_n already high, which only a finished negotiation leaves behind. A second-phase timeout needs a peripheral that answers the first termination step but never raises acknowledge. The bench therefore includes a reactive peripheral model that follows the host pins. Its per-step response switches let each stage answer or stay silent on its own, and directed sequences chain a successful negotiation into the refused request and into each termination fault. Tick pulses are counted while the controller is busy, so that the timeout limits can be checked exactly.

// File: rtl/pp_neg_pkg.sv
package pp_neg_pkg;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_IOERR   = 2'd2,
        RES_NOSUPP  = 2'd3
    } neg_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_N_SETUP,
        ST_N_EV2,
        ST_N_EV3,
        ST_N_EV6,
        ST_T_EV23,
        ST_T_EV27
    } neg_state_e;

    // host-driven control lines (all active low on the wire)
    typedef struct packed {
        logic selin_n;
        logic afd_n;
        logic stb_n;
        logic init_n;
    } host_pins_t;

    // peripheral status lines after synchronization
    typedef struct packed {
        logic ack_n;
        logic busy;
        logic perror;
        logic select;
        logic fault_n;
    } periph_stat_t;

    localparam int STAT_W = $bits(periph_stat_t);
    localparam logic [STAT_W-1:0] STAT_RST = 5'b1_0_0_0_1;

    localparam host_pins_t PINS_IDLE = '{selin_n: 1'b0, afd_n: 1'b1, stb_n: 1'b1, init_n: 1'b1};
    localparam host_pins_t PINS_REQ  = '{selin_n: 1'b1, afd_n: 1'b0, stb_n: 1'b1, init_n: 1'b1};
    localparam host_pins_t PINS_LTCH = '{selin_n: 1'b1, afd_n: 1'b0, stb_n: 1'b0, init_n: 1'b1};
    localparam host_pins_t PINS_RLSE = '{selin_n: 1'b1, afd_n: 1'b1, stb_n: 1'b1, init_n: 1'b1};
    localparam host_pins_t PINS_TACK = '{selin_n: 1'b0, afd_n: 1'b0, stb_n: 1'b1, init_n: 1'b1};

    localparam logic [7:0] MODE_NIBBLE = 8'h00;

    function automatic logic neg_reply_seen(periph_stat_t s);
        return s.perror & s.select & s.fault_n & ~s.ack_n;
    endfunction

    function automatic logic term_reply_seen(periph_stat_t s);
        return s.busy & s.fault_n & ~s.ack_n;
    endfunction

    function automatic neg_res_e accept_rule(logic [7:0] mode, periph_stat_t s);
        return ((mode == MODE_NIBBLE) || s.select) ? RES_OK : RES_NOSUPP;
    endfunction

endpackage

// File: rtl/pp_neg_sync.sv
module pp_neg_sync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pp_neg_tick_timer.sv
module pp_neg_tick_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick && (cnt != {CW{1'b1}}))
            cnt <= cnt + 1'b1;
    end

    // the tick that brings the count to the limit ends the window
    assign expire = tick && (cnt == (limit - 1'b1));
endmodule

// File: rtl/pp_negotiator.sv
module pp_negotiator
    import pp_neg_pkg::*;
#(
    parameter int SETUP_TICKS = 1,
    parameter int RESP_TICKS  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       neg_req,
    input  logic [7:0] neg_mode,
    input  logic       term_req,
    input  logic       periph_ack_n,
    input  logic       periph_busy,
    input  logic       periph_perror,
    input  logic       periph_select,
    input  logic       periph_fault_n,
    output logic [7:0] data_out,
    output logic       host_selin_n,
    output logic       host_afd_n,
    output logic       host_stb_n,
    output logic       host_init_n,
    output logic       ctl_busy,
    output logic       ctl_done,
    output logic [1:0] ctl_result,
    output logic       link_active
);
    localparam int LONG_TICKS = SETUP_TICKS + RESP_TICKS;
    localparam int CW         = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LIM_SETUP = CW'(SETUP_TICKS);
    localparam logic [CW-1:0] LIM_RESP  = CW'(RESP_TICKS);
    localparam logic [CW-1:0] LIM_LONG  = CW'(LONG_TICKS);

    // status synchronization
    periph_stat_t stat;
    logic [STAT_W-1:0] stat_raw, stat_sync;

    assign stat_raw = {periph_ack_n, periph_busy, periph_perror, periph_select, periph_fault_n};

    pp_neg_sync #(
        .W       (STAT_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (STAT_RST)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (stat_raw),
        .dout (stat_sync)
    );

    assign stat = periph_stat_t'(stat_sync);

    // state
    neg_state_e st, st_n;
    host_pins_t pins, pins_n;
    logic [7:0] data_q, data_n;
    logic       done_q, done_n;
    neg_res_e   res_q, res_n;
    logic       link_q, link_n;

    logic          tmr_clr, tmr_exp;
    logic [CW-1:0] tmr_lim;

    always_comb begin
        unique case (st)
            ST_N_SETUP, ST_N_EV3: tmr_lim = LIM_SETUP;
            ST_N_EV2,  ST_T_EV27: tmr_lim = LIM_RESP;
            default:              tmr_lim = LIM_LONG;
        endcase
    end

    assign tmr_clr = (st_n != st);

    pp_neg_tick_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .tick   (tick),
        .limit  (tmr_lim),
        .expire (tmr_exp)
    );

    always_comb begin
        st_n   = st;
        pins_n = pins;
        data_n = data_q;
        done_n = done_q;
        res_n  = res_q;
        link_n = link_q;
        unique case (st)
            ST_IDLE: begin
                if (neg_req) begin
                    if (pins.selin_n) begin
                        done_n = 1'b1;
                        res_n  = RES_IOERR;
                    end else begin
                        st_n   = ST_N_SETUP;
                        done_n = 1'b0;
                        data_n = neg_mode;
                        link_n = 1'b0;
                    end
                end else if (term_req) begin
                    st_n   = ST_T_EV23;
                    done_n = 1'b0;
                    pins_n = PINS_IDLE;
                end
            end
            ST_N_SETUP: begin
                if (tmr_exp) begin
                    pins_n = PINS_REQ;
                    st_n   = ST_N_EV2;
                end
            end
            ST_N_EV2: begin
                if (neg_reply_seen(stat)) begin
                    pins_n = PINS_LTCH;
                    st_n   = ST_N_EV3;
                end else if (tmr_exp) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                    res_n  = RES_TIMEOUT;
                end
            end
            ST_N_EV3: begin
                if (tmr_exp) begin
                    pins_n = PINS_RLSE;
                    st_n   = ST_N_EV6;
                end
            end
            ST_N_EV6: begin
                if (stat.ack_n) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                    res_n  = accept_rule(data_q, stat);
                    link_n = (accept_rule(data_q, stat) == RES_OK);
                end else if (tmr_exp) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                    res_n  = RES_IOERR;
                end
            end
            ST_T_EV23: begin
                if (term_reply_seen(stat)) begin
                    pins_n = PINS_TACK;
                    st_n   = ST_T_EV27;
                end else if (tmr_exp) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                    res_n  = RES_IOERR;
                    link_n = 1'b0;
                end
            end
            ST_T_EV27: begin
                if (stat.ack_n || tmr_exp) begin
                    pins_n = PINS_IDLE;
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                    res_n  = stat.ack_n ? RES_OK : RES_IOERR;
                    link_n = 1'b0;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            pins   <= PINS_IDLE;
            data_q <= '0;
            done_q <= 1'b0;
            res_q  <= RES_OK;
            link_q <= 1'b0;
        end else begin
            st     <= st_n;
            pins   <= pins_n;
            data_q <= data_n;
            done_q <= done_n;
            res_q  <= res_n;
            link_q <= link_n;
        end
    end

    assign data_out     = data_q;
    assign host_selin_n = pins.selin_n;
    assign host_afd_n   = pins.afd_n;
    assign host_stb_n   = pins.stb_n;
    assign host_init_n  = pins.init_n;
    assign ctl_busy     = (st != ST_IDLE);
    assign ctl_done     = done_q;
    assign ctl_result   = res_q;
    assign link_active  = link_q;
endmodule

// File: rtl/pp_negotiator_chk.sv
module pp_negotiator_chk (
    input logic       clk,
    input logic       rst,
    input logic       neg_req,
    input logic       term_req,
    input logic [7:0] data_out,
    input logic       host_selin_n,
    input logic       host_afd_n,
    input logic       host_stb_n,
    input logic       ctl_busy,
    input logic       ctl_done,
    input logic [1:0] ctl_result,
    input logic       link_active
);
    // R10: busy and done never overlap
    a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        ctl_busy |-> !ctl_done);

    // R10: a held result does not move without a new request
    a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
        (ctl_done && $past(ctl_done) && !$past(neg_req) && !$past(term_req)) |-> $stable(ctl_result));

    // R5: strobe only pulses while select-in is raised and auto-feed is low
    a_r5_strobe_context: assert property (@(posedge clk) disable iff (rst)
        !host_stb_n |-> (host_selin_n && !host_afd_n));

    // R3: the mode code does not change during an operation
    a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl_busy && $past(ctl_busy)) |-> $stable(data_out));

    // R7: the link goes active only with an accepted result
    a_r7_link_only_ok: assert property (@(posedge clk) disable iff (rst)
        $rose(link_active) |-> (ctl_done && ctl_result == 2'd0));

    // R9: the end of a termination leaves the link inactive
    a_r9_term_clears_link: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl_busy) && !host_selin_n) |-> !link_active);
endmodule

bind pp_negotiator pp_negotiator_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .neg_req      (neg_req),
    .term_req     (term_req),
    .data_out     (data_out),
    .host_selin_n (host_selin_n),
    .host_afd_n   (host_afd_n),
    .host_stb_n   (host_stb_n),
    .ctl_busy     (ctl_busy),
    .ctl_done     (ctl_done),
    .ctl_result   (ctl_result),
    .link_active  (link_active)
);

// File: tb/pp_negotiator_test.sv
module pp_negotiator_test;
    localparam int SETUP = 1;
    localparam int RESP  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic neg_req = 1'b0, term_req = 1'b0;
    logic [7:0] neg_mode = 8'h00;
    logic p_ack_n = 1'b1, p_busy = 1'b0, p_perror = 1'b0, p_select = 1'b0, p_fault_n = 1'b1;
    logic [7:0] data_out;
    logic selin_n, afd_n, stb_n, init_n;
    logic busy, done, link;
    logic [1:0] result;

    always #5 clk = ~clk;

    pp_negotiator #(.SETUP_TICKS(SETUP), .RESP_TICKS(RESP)) uut (
        .clk(clk), .rst(rst), .tick(tick),
        .neg_req(neg_req), .neg_mode(neg_mode), .term_req(term_req),
        .periph_ack_n(p_ack_n), .periph_busy(p_busy), .periph_perror(p_perror),
        .periph_select(p_select), .periph_fault_n(p_fault_n),
        .data_out(data_out), .host_selin_n(selin_n), .host_afd_n(afd_n),
        .host_stb_n(stb_n), .host_init_n(init_n),
        .ctl_busy(busy), .ctl_done(done), .ctl_result(result), .link_active(link)
    );

    // time base: one tick every fourth cycle
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv <= (tdiv + 1) % 4;
        tick <= (tdiv == 3);
    end

    // tick monitors
    logic cnt_clr = 1'b0;
    int busy_ticks = 0, stb_ticks = 0;
    always @(posedge clk) begin
        if (cnt_clr) begin
            busy_ticks <= 0;
            stb_ticks  <= 0;
        end else begin
            if (tick && busy)   busy_ticks <= busy_ticks + 1;
            if (tick && !stb_n) stb_ticks  <= stb_ticks + 1;
        end
    end

    // reactive peripheral model
    logic c_r2 = 1, c_sel = 1, c_r6 = 1, c_t1 = 1, c_t2 = 1;
    logic term_go = 0, p_base = 0;
    always @(negedge clk) begin
        if (p_base) begin
            p_ack_n = 1; p_busy = 0; p_perror = 0; p_select = 0; p_fault_n = 1;
        end else if (selin_n) begin
            if (!afd_n && stb_n && c_r2) begin
                p_ack_n = 0; p_perror = 1; p_select = 1; p_fault_n = 1;
            end
            if (!stb_n) p_select = c_sel;
            if (afd_n && stb_n && c_r6) p_ack_n = 1;
        end else if (term_go) begin
            if (afd_n && c_t1) begin
                p_busy = 1; p_ack_n = 0; p_fault_n = 1;
            end
            if (!afd_n && c_t2) p_ack_n = 1;
        end
    end

    int total = 0, bad = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk("R10 done within limit", int'(done), 1);
    endtask

    task automatic clr_cnt();
        @(negedge clk) cnt_clr = 1;
        @(negedge clk) cnt_clr = 0;
    endtask

    task automatic negotiate(input logic [7:0] m);
        p_base = 1;
        clr_cnt();
        p_base = 0;
        @(negedge clk);
        neg_mode = m;
        neg_req  = 1;
        @(negedge clk);
        neg_req  = 0;
        chk("R10 busy after accept", int'(busy), 1);
        wait_done();
    endtask

    task automatic terminate();
        clr_cnt();
        term_go  = 1;
        term_req = 1;
        @(negedge clk);
        term_req = 0;
        wait_done();
        term_go = 0;
        chk("R9 pins idle selin", int'(selin_n), 0);
        chk("R9 pins idle afd", int'(afd_n), 1);
        chk("R9 pins idle stb", int'(stb_n), 1);
        chk("R9 link cleared", int'(link), 0);
    endtask

    // {mode[7:0], r2, sel, r6, result[1:0]}
    localparam int NV = 6;
    localparam logic [12:0] VEC [NV] = '{
        {8'h00, 1'b1, 1'b0, 1'b1, 2'd0},
        {8'h10, 1'b1, 1'b1, 1'b1, 2'd0},
        {8'h30, 1'b1, 1'b0, 1'b1, 2'd3},
        {8'h14, 1'b0, 1'b1, 1'b1, 2'd1},
        {8'h00, 1'b1, 1'b1, 1'b0, 2'd2},
        {8'h55, 1'b1, 1'b1, 1'b1, 2'd0}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 selin_n", int'(selin_n), 0);
        chk("R1 afd_n", int'(afd_n), 1);
        chk("R1 stb_n", int'(stb_n), 1);
        chk("R1 init_n", int'(init_n), 1);
        chk("R1 busy/done/link", int'({busy, done, link}), 0);
        chk("R1 data", int'(data_out), 0);

        for (int i = 0; i < NV; i++) begin
            c_r2 = VEC[i][4]; c_sel = VEC[i][3]; c_r6 = VEC[i][2];
            negotiate(VEC[i][12:5]);
            chk("R7 vector result", int'(result), int'(VEC[i][1:0]));
            chk("R7 link on accept", int'(link), int'(VEC[i][1:0] == 2'd0));
            chk("R3 data_out", int'(data_out), int'(VEC[i][12:5]));
            if (VEC[i][1:0] == 2'd1) begin
                chk("R4 timeout ticks", busy_ticks, SETUP + RESP);
                chk("R4 pins held at request", int'({selin_n, afd_n, stb_n, init_n}), 4'b1011);
            end else begin
                chk("R5 strobe ticks", stb_ticks, SETUP);
                chk("R5 strobe and afd released", int'({afd_n, stb_n}), 2'b11);
            end
            if (VEC[i][1:0] == 2'd2) chk("R6 ack missing ticks", int'(busy_ticks >= SETUP + SETUP + RESP), 1);
            c_t1 = 1; c_t2 = 1;
            terminate();
            chk("R9 term ok", int'(result), 0);
        end

        // R2: refusal while select-in is already high
        c_r2 = 1; c_sel = 1; c_r6 = 1;
        negotiate(8'h10);
        chk("R7 accept 0x10", int'(result), 0);
        @(negedge clk);
        neg_mode = 8'h20; neg_req = 1;
        @(negedge clk);
        neg_req = 0;
        chk("R2 refusal done", int'(done), 1);
        chk("R2 refusal result", int'(result), 2);
        chk("R2 no busy", int'(busy), 0);
        chk("R2 link kept", int'(link), 1);
        chk("R2 data kept", int'(data_out), 8'h10);
        chk("R2 selin kept", int'(selin_n), 1);

        // R8: first termination step never answered
        c_t1 = 0;
        terminate();
        chk("R8 timeout result", int'(result), 2);
        chk("R8 timeout ticks", busy_ticks, SETUP + RESP);

        // R9: second termination step never answered
        c_t1 = 1; c_t2 = 0;
        negotiate(8'h00);
        chk("R7 nibble ok", int'(result), 0);
        terminate();
        chk("R9 phase2 timeout result", int'(result), 2);
        c_t2 = 1;

        // R10: termination request while busy is ignored
        p_base = 1;
        clr_cnt();
        p_base = 0;
        neg_mode = 8'h22; neg_req = 1;
        @(negedge clk);
        neg_req = 0;
        repeat (2) @(negedge clk);
        term_req = 1;
        @(negedge clk);
        term_req = 0;
        wait_done();
        chk("R10 ignored term result", int'(result), 0);
        chk("R10 ignored term link", int'(link), 1);
        chk("R10 ignored term selin", int'(selin_n), 1);
        repeat (20) @(negedge clk);
        chk("R10 done held", int'(done), 1);
        chk("R10 result held", int'(result), 0);
        terminate();

        // R10: negotiation wins over simultaneous termination
        p_base = 1;
        clr_cnt();
        p_base = 0;
        neg_mode = 8'h00; neg_req = 1; term_req = 1;
        @(negedge clk);
        neg_req = 0; term_req = 0;
        wait_done();
        chk("R10 priority link", int'(link), 1);
        chk("R10 priority data", int'(data_out), 0);
        terminate();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end
endmodule